// File: doc/BRIEF.md
# UART Receive Queue with Line Status

This block sits between a UART receiver and the host. Each time the receiver finishes a character, it hands over the data byte and a parity-error indication. The block stores both together in a 32-entry first-in first-out queue. The host sees the oldest stored byte at all times. It pops that byte by pulsing a holding-register read strobe.

Three line-status flags are produced for the host. The data-ready flag is high whenever at least one character is waiting. The overrun flag records that a character arrived while the queue had no free slot. The parity-error flag always describes the character at the head of the queue, never the newest arrival.

When an overrun happens, the arriving character is thrown away and the stored characters stay intact. The overrun flag is sticky: it stays high until the host pulses the status-register read strobe. Bit sampling, framing and interrupt generation belong to other blocks.

Top module: `uart_rx_fifo_status`

## Requirements
- R1: The queue holds exactly DEPTH (default 32) characters. A character that completes while all DEPTH slots are occupied, with no host pop in the same cycle, is not stored.
- R2: `data_ready_o` is 1 exactly when the queue holds at least one character. It changes in the cycle after the clock edge on which a push or a pop is accepted.
- R3: Characters leave in arrival order. `head_data_o` presents the oldest stored byte, and a pop on a clock edge exposes the next byte after that edge.
- R4: `parity_err_o` equals the parity tag stored with the head character. It is 0 whenever the queue is empty.
- R5: A discarded overrun character leaves the stored bytes, their tags and their order unchanged.
- R6: `overrun_o` goes to 1 on the edge after a discarded character and stays 1 until an edge on which `lsr_read_i` is high. If a new discard lands on that same edge, the flag stays 1.
- R7: A holding-register read on an empty queue moves no pointer. `head_data_o` keeps showing the byte most recently popped, or 0 if nothing has been popped since reset.
- R8: On a full queue, a push and a pop in the same cycle are both accepted. The queue stays full and `overrun_o` is not set.
- R9: After reset, `data_ready_o`, `overrun_o`, `parity_err_o` and `head_data_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_valid_i | input | 1 | One-cycle strobe: receiver finished a character |
| char_data_i | input | 8 | Received data byte |
| char_perr_i | input | 1 | Parity error detected on this character |
| rhr_read_i | input | 1 | Host pops the head character |
| lsr_read_i | input | 1 | Host reads the status; clears the overrun flag |
| head_data_o | output | 8 | Byte at the queue head (or last popped byte when empty) |
| data_ready_o | output | 1 | At least one character stored |
| overrun_o | output | 1 | Sticky overrun indication |
| parity_err_o | output | 1 | Parity tag of the head character |

## Verification
A push and a pop can land on the same edge. The bench provokes this on a full queue, where it must be accepted without overrun, and also at every fill level during a long interleaved sweep. A new discard and a status read can also coincide. The bench forces this by pushing into a full queue while pulsing the status read, and requires the overrun flag to remain set. In both cases every output is compared before each edge against a queue model kept in the bench.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  parameter int unsigned RXQ_DATA_W = 8;

  typedef struct packed {
    logic                  perr;
    logic [RXQ_DATA_W-1:0] data;
  } rxq_entry_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter  int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_req_i,
  input  logic             pop_req_i,
  output logic             wr_en_o,
  output logic             pop_en_o,
  output logic             drop_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty_o  = (cnt_q == '0);
  assign full_o   = (cnt_q == CNT_W'(DEPTH));
  assign pop_en_o = pop_req_i & ~empty_o;
  // a pop on the same edge frees the slot for the incoming character
  assign wr_en_o  = push_req_i & (~full_o | pop_en_o);
  assign drop_o   = push_req_i & full_o & ~pop_en_o;
  assign wr_ptr_o = wr_ptr_q;
  assign rd_ptr_o = rd_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_en_o)  wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_en_o) rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({wr_en_o, pop_en_o})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  p_drop_keeps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |=> full_o && $stable(wr_ptr_q) && $stable(rd_ptr_q));

  p_empty_pop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_req_i && !push_req_i) |=> empty_o && $stable(rd_ptr_q));

  p_full_both_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_req_i && pop_req_i) |=> full_o);
endmodule

// File: rtl/rxq_mem.sv
module rxq_mem
  import rxq_pkg::*;
#(
  parameter  int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_ptr_i,
  input  rxq_entry_t       wr_entry_i,
  input  logic [PTR_W-1:0] rd_ptr_i,
  output rxq_entry_t       rd_entry_o
);
  rxq_entry_t slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      slot_q[i] <= '0;
      else if (wr_en_i && (wr_ptr_i == PTR_W'(i)))      slot_q[i] <= wr_entry_i;
    end
  end

  assign rd_entry_o = slot_q[rd_ptr_i];
endmodule

// File: rtl/rxq_head.sv
module rxq_head
  import rxq_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  empty_i,
  input  logic                  pop_en_i,
  input  rxq_entry_t            rd_entry_i,
  output logic [RXQ_DATA_W-1:0] head_data_o,
  output logic                  parity_err_o,
  output logic                  data_ready_o
);
  logic [RXQ_DATA_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_q <= '0;
    else if (pop_en_i) last_q <= rd_entry_i.data;
  end

  assign head_data_o  = empty_i ? last_q : rd_entry_i.data;
  assign parity_err_o = ~empty_i & rd_entry_i.perr;
  assign data_ready_o = ~empty_i;

  p_hold_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_i && $past(empty_i)) |-> $stable(head_data_o));

  p_pop_exposes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_en_i |=> (last_q == $past(rd_entry_i.data)));
endmodule

// File: rtl/rxq_line_flags.sv
module rxq_line_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drop_i,
  input  logic lsr_read_i,
  output logic overrun_o
);
  logic ovr_q;

  // a new drop wins over a clearing status read on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ovr_q <= 1'b0;
    else if (drop_i)     ovr_q <= 1'b1;
    else if (lsr_read_i) ovr_q <= 1'b0;
  end

  assign overrun_o = ovr_q;

  p_ovr_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> overrun_o);

  p_ovr_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_read_i && !drop_i) |=> !overrun_o);

  p_ovr_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !lsr_read_i) |=> overrun_o);
endmodule

// File: rtl/uart_rx_fifo_status.sv
module uart_rx_fifo_status
  import rxq_pkg::*;
#(
  parameter  int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  char_valid_i,
  input  logic [RXQ_DATA_W-1:0] char_data_i,
  input  logic                  char_perr_i,
  input  logic                  rhr_read_i,
  input  logic                  lsr_read_i,
  output logic [RXQ_DATA_W-1:0] head_data_o,
  output logic                  data_ready_o,
  output logic                  overrun_o,
  output logic                  parity_err_o
);
  logic             wr_en, pop_en, drop, empty, full;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  rxq_entry_t       wr_entry, rd_entry;

  assign wr_entry.data = char_data_i;
  assign wr_entry.perr = char_perr_i;

  rxq_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk_i, .rst_ni,
    .push_req_i (char_valid_i),
    .pop_req_i  (rhr_read_i),
    .wr_en_o    (wr_en),
    .pop_en_o   (pop_en),
    .drop_o     (drop),
    .wr_ptr_o   (wr_ptr),
    .rd_ptr_o   (rd_ptr),
    .empty_o    (empty),
    .full_o     (full)
  );

  rxq_mem #(.DEPTH(DEPTH)) i_mem (
    .clk_i, .rst_ni,
    .wr_en_i    (wr_en),
    .wr_ptr_i   (wr_ptr),
    .wr_entry_i (wr_entry),
    .rd_ptr_i   (rd_ptr),
    .rd_entry_o (rd_entry)
  );

  rxq_head i_head (
    .clk_i, .rst_ni,
    .empty_i      (empty),
    .pop_en_i     (pop_en),
    .rd_entry_i   (rd_entry),
    .head_data_o  (head_data_o),
    .parity_err_o (parity_err_o),
    .data_ready_o (data_ready_o)
  );

  rxq_line_flags i_flags (
    .clk_i, .rst_ni,
    .drop_i     (drop),
    .lsr_read_i (lsr_read_i),
    .overrun_o  (overrun_o)
  );

  p_full_drop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && full && !rhr_read_i) |-> !wr_en);

  p_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && !full) |=> data_ready_o);

  p_perr_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_ready_o |-> !parity_err_o);
endmodule

// File: tb/test_uart_rx_fifo_status.sv
module test_uart_rx_fifo_status;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 32;

  logic       clk = 0, rst_n = 0;
  logic       valid = 0, perr = 0, rrd = 0, lrd = 0;
  logic [7:0] data = 0;
  logic [7:0] head;
  logic       ready, ovr, perr_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [8:0] mq[$];
  logic [7:0] m_last = 0;
  logic       m_ovr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_fifo_status #(.DEPTH(DEPTH)) i_uart_rx_fifo_status (
    .clk_i(clk), .rst_ni(rst_n), .char_valid_i(valid), .char_data_i(data),
    .char_perr_i(perr), .rhr_read_i(rrd), .lsr_read_i(lrd),
    .head_data_o(head), .data_ready_o(ready), .overrun_o(ovr), .parity_err_o(perr_o));

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // compare all outputs against the model, then apply one cycle of stimulus
  task automatic cyc(input bit v, input logic [7:0] d, input bit p,
                     input bit r, input bit l);
    bit popd, drop;
    @(negedge clk);
    chk("R2 ready", int'(ready), int'(mq.size() != 0));
    chk("R6 overrun", int'(ovr), int'(m_ovr));
    chk("R4 parity", int'(perr_o), mq.size() != 0 ? int'(mq[0][8]) : 0);
    chk("R3/R7 head", int'(head), mq.size() != 0 ? int'(mq[0][7:0]) : int'(m_last));
    valid = v; data = d; perr = p; rrd = r; lrd = l;
    @(posedge clk);
    popd = r && mq.size() != 0;
    drop = v && mq.size() == DEPTH && !popd;
    if (popd) begin m_last = mq[0][7:0]; void'(mq.pop_front()); end
    if (v && !drop) mq.push_back({p, d});
    if (drop) m_ovr = 1;
    else if (l) m_ovr = 0;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset values
    chk("R9 ready", int'(ready), 0);
    chk("R9 overrun", int'(ovr), 0);
    chk("R9 parity", int'(perr_o), 0);
    chk("R9 head", int'(head), 0);
    rst_n = 1;

    // R1 fill all 32 slots
    for (int i = 0; i < DEPTH; i++) cyc(1, pat(i), (i % 3) == 0, 0, 0);
    // R1/R5 extra character while full is discarded, flag set
    cyc(1, 8'hEE, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R1 overrun set", int'(ovr), 1);
    chk("R5 head kept", int'(head), int'(pat(0)));
    // R6 status read clears
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0);
    chk("R6 cleared", int'(ovr), 0);
    // R8 push and pop together on full
    cyc(1, 8'h5A, 1, 1, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R8 no overrun", int'(ovr), 0);
    chk("R8 still full head", int'(head), int'(pat(1)));
    // R3/R4/R5 drain, order and tags checked inside cyc
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R2 empty", int'(ready), 0);
    chk("R7 last popped", int'(head), 8'h5A);
    // R7 reads on empty change nothing
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R7 hold", int'(head), 8'h5A);
    cyc(1, 8'h33, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R7 next push", int'(head), 8'h33);
    // R6 new drop on the same edge as a status read keeps the flag
    for (int i = 1; i < DEPTH; i++) cyc(1, pat(i + 50), i[0], 0, 0);
    cyc(1, 8'hC3, 0, 0, 1);
    cyc(0, 0, 0, 0, 0);
    chk("R6 drop beats clear", int'(ovr), 1);
    cyc(0, 0, 0, 0, 1);
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 1, 0);
    // interleaved sweep over all fill levels and wrap points
    for (int k = 0; k < 3000; k++)
      cyc((k % 3) != 0 || (k % 7) == 0, pat(k + 9), (k % 5) == 1,
          ((k / 97) % 2 == 0) ? (k % 2 == 0) : (k % 4 == 0), (k % 11) == 0);
    cyc(0, 0, 0, 0, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule